// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the state machine that steers a multicycle 32-bit load/store processor in which one memory holds both code and data and a single ALU is reused in every step. It looks only at the 6-bit opcode held in the instruction register and at the ALU's zero and overflow flags. From its current state it drives every select and write enable of the datapath. Each output depends on the state alone, except the combined program-counter enable, which also depends on the zero flag.

Every instruction starts with a fetch step and a decode step. The sequencer then follows one of five paths: load (5 cycles in total), store (4), register arithmetic (4), branch-if-equal (3) or jump (3). It then returns to fetch. An unknown opcode, or an arithmetic overflow in the register-arithmetic execute step, sends it to an exception step. That step saves the faulting instruction address, records a cause code and redirects the program counter to the fixed handler vector.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in the fetch state (code 4'b0000). The cycle after reset is released shows the fetch outputs. This also holds when reset arrives in the middle of an instruction.
- R2: In fetch, mem_rd=1, ir_wr=1, pc_wr=1, alu_b_sel=2'b01 and alu_a_sel=0, with alu_op=2'b00, pc_src=2'b00 and addr_sel=0. Fetch is always followed by decode (code 4'b0001).
- R3: In decode, alu_a_sel=0, alu_b_sel=2'b11 and alu_op=2'b00. The next step is chosen by opcode: 6'b100011 (load) and 6'b101011 (store) go to address computation, 6'b000000 goes to register execute, 6'b000100 goes to branch and 6'b000010 goes to jump.
- R4: A load passes through three further steps. Address computation has alu_a_sel=1 and alu_b_sel=2'b10. Memory read has mem_rd=1 and addr_sel=1. Register write-back has reg_wr=1, wb_from_mem=1 and dst_sel=0.
- R5: A store passes through address computation and then a memory-write step with mem_wr=1 and addr_sel=1, and then returns to fetch.
- R6: A register-arithmetic instruction passes through an execute step (alu_a_sel=1, alu_b_sel=2'b00, alu_op=2'b10) and then a write-back step (reg_wr=1, wb_from_mem=0, dst_sel=1).
- R7: The branch step drives pc_wr_cond=1, alu_a_sel=1, alu_b_sel=2'b00, alu_op=2'b01 and pc_src=2'b01. The program counter is enabled only when alu_zero=1.
- R8: The jump step drives pc_wr=1 and pc_src=2'b10.
- R9: pc_en is high when pc_wr is high, or when pc_wr_cond and alu_zero are both high. It is low otherwise.
- R10: An opcode other than the five listed in R3 sends decode to the exception step, with cause_val=0.
- R11: Overflow during register execute sends the sequencer to the exception step with cause_val=1, and the write-back step is skipped. Overflow in any other state has no effect on the sequence.
- R12: The exception step drives epc_wr=1, cause_wr=1, pc_wr=1, alu_a_sel=0, alu_b_sel=2'b01, alu_op=2'b01 and pc_src=2'b11. It then returns to fetch.
- R13: Every output that a state does not name is 0. cause_val is 0 outside the exception step, and mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result is all zeros |
| alu_ovf | input | 1 | ALU signed overflow |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write when zero is set |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wb_from_mem | output | 1 | Register write data: 0 = ALU output, 1 = memory data register |
| ir_wr | output | 1 | Instruction register write |
| dst_sel | output | 1 | Destination: 0 = bits 20:16, 1 = bits 15:11 |
| reg_wr | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 00 B reg, 01 constant 4, 10 sign-extended immediate, 11 shifted immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | 00 ALU, 01 ALU output register, 10 jump target, 11 handler vector |
| epc_wr | output | 1 | Exception PC register write |
| cause_wr | output | 1 | Cause register write |
| cause_val | output | 32 | Cause code: 0 undefined opcode, 1 overflow |
| pc_en | output | 1 | Combined program-counter write enable |

## Verification
The assertions check the following on every cycle: the enable cannot fire on a branch whose zero flag is low, memory is never read and written at once, and fetch always follows the exception step and the branch step. They also check that a memory read is followed by a load write-back, and that overflow in the execute step lands in the exception step with cause 1 and no register write. Only the bench's scenarios can show full paths. They cover the exact cycle count of each instruction class and the complete output vector in every step. They also show that flags arriving in the wrong state are ignored, and that reset in the middle of an instruction recovers into fetch.

// File: rtl/mc_ctrl_pkg.sv
// Package: shared encodings for the multicycle control sequencer.
// Holds the state codes, the opcodes it dispatches on, the cause codes and
// the control-word layout shared by the decode logic and the top.
package mc_ctrl_pkg;

    localparam int STATE_W = 4;
    localparam int OPC_W   = 6;

    // Fetch and decode keep codes 0 and 1; the rest are free choices.
    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_MRD    = 4'd3,
        ST_LDWB   = 4'd4,
        ST_MWR    = 4'd5,
        ST_REXE   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9,
        ST_EXC    = 4'd10
    } state_t;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

    // Cause identifiers, widened to the output width at the top.
    typedef enum logic {
        CZ_UNDEF = 1'b0,
        CZ_OVF   = 1'b1
    } cause_t;

    // Selector encodings.
    localparam logic [1:0] BSEL_BREG  = 2'b00;
    localparam logic [1:0] BSEL_FOUR  = 2'b01;
    localparam logic [1:0] BSEL_IMM   = 2'b10;
    localparam logic [1:0] BSEL_IMMSH = 2'b11;
    localparam logic [1:0] AOP_ADD    = 2'b00;
    localparam logic [1:0] AOP_SUB    = 2'b01;
    localparam logic [1:0] AOP_FUNCT  = 2'b10;
    localparam logic [1:0] PCS_ALU    = 2'b00;
    localparam logic [1:0] PCS_ALUOUT = 2'b01;
    localparam logic [1:0] PCS_JUMP   = 2'b10;
    localparam logic [1:0] PCS_VECTOR = 2'b11;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       wb_from_mem;
        logic       ir_wr;
        logic       dst_sel;
        logic       reg_wr;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic [1:0] pc_src;
        logic       epc_wr;
        logic       cause_wr;
    } ctl_t;

endpackage

// File: rtl/mc_next_state.sv
// Module: next-state logic of the control sequencer.
// Purely combinational. It picks the following state from the current one,
// the opcode and the overflow flag. It also reports when the exception step
// is being entered and which cause applies.
// Assumes the opcode is stable from decode until the instruction retires.
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_t           cur_st,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_ovf,
    output state_t           nxt_st,
    output logic             exc_enter,
    output cause_t           exc_cause
);

    // Dispatch table: one arm per state, illegal codes recover into fetch.
    always_comb begin
        nxt_st    = ST_FETCH;
        exc_enter = 1'b0;
        exc_cause = CZ_UNDEF;
        unique case (cur_st)
            ST_FETCH:  nxt_st = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_LOAD,
                    OPC_STORE: nxt_st = ST_ADDR;
                    OPC_RTYPE: nxt_st = ST_REXE;
                    OPC_BEQ:   nxt_st = ST_BRANCH;
                    OPC_JUMP:  nxt_st = ST_JUMP;
                    default: begin
                        nxt_st    = ST_EXC;
                        exc_enter = 1'b1;
                        exc_cause = CZ_UNDEF;
                    end
                endcase
            end
            ST_ADDR:   nxt_st = (opcode == OPC_LOAD) ? ST_MRD : ST_MWR;
            ST_MRD:    nxt_st = ST_LDWB;
            ST_REXE: begin
                if (alu_ovf) begin
                    nxt_st    = ST_EXC;
                    exc_enter = 1'b1;
                    exc_cause = CZ_OVF;
                end else begin
                    nxt_st = ST_RWB;
                end
            end
            ST_LDWB, ST_MWR, ST_RWB, ST_BRANCH, ST_JUMP, ST_EXC:
                       nxt_st = ST_FETCH;
            default:   nxt_st = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_state_reg.sv
// Module: state and cause registers of the control sequencer.
// Holds the current state and the cause that was latched when the exception
// step was entered. The reset is synchronous and active low, and it forces
// the fetch state.
module mc_state_reg
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t nxt_st,
    input  logic   exc_enter,
    input  cause_t exc_cause,
    output state_t cur_st,
    output cause_t cause_q
);

    // Advance the state every cycle; reset returns to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= ST_FETCH;
        else        cur_st <= nxt_st;
    end

    // Capture the cause only on entry to the exception step.
    always_ff @(posedge clk) begin
        if (!rst_n)         cause_q <= CZ_UNDEF;
        else if (exc_enter) cause_q <= exc_cause;
    end

endmodule

// File: rtl/mc_out_decode.sv
// Module: Moore output decode of the control sequencer.
// Maps the current state to a full control word. Every field starts at
// zero, so each state sets only the fields it uses. The cause code is
// widened to CAUSE_W and shown only in the exception step.
module mc_out_decode
    import mc_ctrl_pkg::*;
#(
    parameter int CAUSE_W = 32
) (
    input  state_t             cur_st,
    input  cause_t             cause_q,
    output ctl_t               ctl,
    output logic [CAUSE_W-1:0] cause_val
);

    // Per-state control word with zero defaults.
    always_comb begin
        ctl = '0;
        unique case (cur_st)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_op    = AOP_ADD;
                ctl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSEL_IMMSH;
                ctl.alu_op    = AOP_ADD;
            end
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_op    = AOP_ADD;
            end
            ST_MRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.reg_wr      = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_MWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_REXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_BREG;
                ctl.alu_op    = AOP_FUNCT;
            end
            ST_RWB: begin
                ctl.reg_wr  = 1'b1;
                ctl.dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctl.pc_wr_cond = 1'b1;
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = BSEL_BREG;
                ctl.alu_op     = AOP_SUB;
                ctl.pc_src     = PCS_ALUOUT;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_JUMP;
            end
            ST_EXC: begin
                ctl.epc_wr    = 1'b1;
                ctl.cause_wr  = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_op    = AOP_SUB;
                ctl.pc_src    = PCS_VECTOR;
            end
            default: ctl = '0;
        endcase
    end

    // Widen the latched cause; zero outside the exception step.
    generate
        if (CAUSE_W > 1) begin : g_wide
            assign cause_val = (cur_st == ST_EXC)
                             ? {{(CAUSE_W-1){1'b0}}, cause_q} : '0;
        end else begin : g_narrow
            assign cause_val = (cur_st == ST_EXC) ? cause_q : 1'b0;
        end
    endgenerate

endmodule

// File: rtl/mc_pc_gate.sv
// Module: program-counter enable merge.
// Combines the unconditional write with the branch write that is qualified
// by the ALU zero flag. Assumes zero is valid in the branch step.
module mc_pc_gate (
    input  logic pc_wr,
    input  logic pc_wr_cond,
    input  logic alu_zero,
    output logic pc_en
);

    // Either write source enables the program counter.
    always_comb pc_en = pc_wr | (pc_wr_cond & alu_zero);

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Module: top of the multicycle processor control sequencer.
// Joins the next-state logic, the state registers, the Moore output decode
// and the PC enable merge. Outputs depend on state only, except pc_en,
// which also sees alu_zero. Assumes the opcode input comes from the
// instruction register, written at the end of fetch.
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [5:0]         opcode,
    input  logic               alu_zero,
    input  logic               alu_ovf,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic               addr_sel,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               wb_from_mem,
    output logic               ir_wr,
    output logic               dst_sel,
    output logic               reg_wr,
    output logic               alu_a_sel,
    output logic [1:0]         alu_b_sel,
    output logic [1:0]         alu_op,
    output logic [1:0]         pc_src,
    output logic               epc_wr,
    output logic               cause_wr,
    output logic [CAUSE_W-1:0] cause_val,
    output logic               pc_en
);

    state_t cur_st;
    state_t nxt_st;
    logic   exc_enter;
    cause_t exc_cause;
    cause_t cause_q;
    ctl_t   ctl;

    mc_next_state u_next (
        .cur_st    (cur_st),
        .opcode    (opcode),
        .alu_ovf   (alu_ovf),
        .nxt_st    (nxt_st),
        .exc_enter (exc_enter),
        .exc_cause (exc_cause)
    );

    mc_state_reg u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_st    (nxt_st),
        .exc_enter (exc_enter),
        .exc_cause (exc_cause),
        .cur_st    (cur_st),
        .cause_q   (cause_q)
    );

    mc_out_decode #(.CAUSE_W(CAUSE_W)) u_dec (
        .cur_st    (cur_st),
        .cause_q   (cause_q),
        .ctl       (ctl),
        .cause_val (cause_val)
    );

    mc_pc_gate u_gate (
        .pc_wr      (ctl.pc_wr),
        .pc_wr_cond (ctl.pc_wr_cond),
        .alu_zero   (alu_zero),
        .pc_en      (pc_en)
    );

    // Fan the control word out to the ports.
    always_comb begin
        pc_wr       = ctl.pc_wr;
        pc_wr_cond  = ctl.pc_wr_cond;
        addr_sel    = ctl.addr_sel;
        mem_rd      = ctl.mem_rd;
        mem_wr      = ctl.mem_wr;
        wb_from_mem = ctl.wb_from_mem;
        ir_wr       = ctl.ir_wr;
        dst_sel     = ctl.dst_sel;
        reg_wr      = ctl.reg_wr;
        alu_a_sel   = ctl.alu_a_sel;
        alu_b_sel   = ctl.alu_b_sel;
        alu_op      = ctl.alu_op;
        pc_src      = ctl.pc_src;
        epc_wr      = ctl.epc_wr;
        cause_wr    = ctl.cause_wr;
    end

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
// Module: property checker for the control sequencer, bound to the top.
// Watches only the ports and relates them over consecutive cycles.
module mc_ctrl_fsm_chk #(
    parameter int CAUSE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alu_zero,
    input logic               alu_ovf,
    input logic               pc_wr,
    input logic               pc_wr_cond,
    input logic               addr_sel,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               wb_from_mem,
    input logic               ir_wr,
    input logic               dst_sel,
    input logic               reg_wr,
    input logic               alu_a_sel,
    input logic [1:0]         alu_b_sel,
    input logic [1:0]         alu_op,
    input logic [1:0]         pc_src,
    input logic               epc_wr,
    input logic               cause_wr,
    input logic [CAUSE_W-1:0] cause_val,
    input logic               pc_en
);

    AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ir_wr && mem_rd && pc_wr && !addr_sel)); // R1

    AST_DECODE_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (alu_b_sel == 2'b11 && !alu_a_sel && !ir_wr)); // R3

    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && addr_sel) |=> (reg_wr && wb_from_mem && !dst_sel)); // R4

    AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond && !alu_zero) |-> !pc_en); // R7

    AST_BRANCH_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |=> ir_wr); // R7

    AST_UNCOND_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr |-> pc_en); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 2'b10 && alu_ovf) |=> (!reg_wr && epc_wr && cause_val == 1)); // R11

    AST_EXC_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |-> (pc_src == 2'b11 && pc_wr && cause_wr)); // R12

    AST_EXC_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |=> ir_wr); // R12

    AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R13

    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |-> (cause_val == '0)); // R13

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(.CAUSE_W(CAUSE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_from_mem(wb_from_mem),
    .ir_wr(ir_wr), .dst_sel(dst_sel), .reg_wr(reg_wr),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_src(pc_src), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .cause_val(cause_val), .pc_en(pc_en)
);

// File: tb/mc_ctrl_fsm_tb.sv
// Scoreboard bench: drivers push one expected item per cycle, and a monitor
// compares the ports against it a little after each falling edge.
module mc_ctrl_fsm_tb;

    localparam int CLK_PERIOD = 10;

    // Control word bit order:
    // pc_wr pc_wr_cond addr_sel mem_rd mem_wr wb_from_mem ir_wr dst_sel
    // reg_wr alu_a_sel alu_b_sel[2] alu_op[2] pc_src[2] epc_wr cause_wr
    localparam logic [17:0] V_FETCH  = 18'b1_0_0_1_0_0_1_0_0_0_01_00_00_0_0;
    localparam logic [17:0] V_DECODE = 18'b0_0_0_0_0_0_0_0_0_0_11_00_00_0_0;
    localparam logic [17:0] V_ADDR   = 18'b0_0_0_0_0_0_0_0_0_1_10_00_00_0_0;
    localparam logic [17:0] V_MRD    = 18'b0_0_1_1_0_0_0_0_0_0_00_00_00_0_0;
    localparam logic [17:0] V_LDWB   = 18'b0_0_0_0_0_1_0_0_1_0_00_00_00_0_0;
    localparam logic [17:0] V_MWR    = 18'b0_0_1_0_1_0_0_0_0_0_00_00_00_0_0;
    localparam logic [17:0] V_REXE   = 18'b0_0_0_0_0_0_0_0_0_1_00_10_00_0_0;
    localparam logic [17:0] V_RWB    = 18'b0_0_0_0_0_0_0_1_1_0_00_00_00_0_0;
    localparam logic [17:0] V_BRANCH = 18'b0_1_0_0_0_0_0_0_0_1_00_01_01_0_0;
    localparam logic [17:0] V_JUMP   = 18'b1_0_0_0_0_0_0_0_0_0_00_00_10_0_0;
    localparam logic [17:0] V_EXC    = 18'b1_0_0_0_0_0_0_0_0_0_01_01_11_1_1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic        alu_zero = 1'b0;
    logic        alu_ovf = 1'b0;
    logic        pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_from_mem;
    logic        ir_wr, dst_sel, reg_wr, alu_a_sel, epc_wr, cause_wr, pc_en;
    logic [1:0]  alu_b_sel, alu_op, pc_src;
    logic [31:0] cause_val;

    typedef struct {
        logic [17:0] ctl;
        logic        en;
        logic [31:0] cause;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_ctrl_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .alu_ovf(alu_ovf), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_from_mem(wb_from_mem), .ir_wr(ir_wr), .dst_sel(dst_sel),
        .reg_wr(reg_wr), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .pc_src(pc_src), .epc_wr(epc_wr),
        .cause_wr(cause_wr), .cause_val(cause_val), .pc_en(pc_en)
    );

    // Drive one cycle's inputs, queue its expectation, wait for the next cycle.
    task automatic cyc(input logic [5:0] op, input logic z, input logic ov,
                       input logic rst, input logic [17:0] ctl,
                       input logic en, input logic [31:0] cz, input string tag);
        exp_t e;
        opcode = op; alu_zero = z; alu_ovf = ov; rst_n = rst;
        e.ctl = ctl; e.en = en; e.cause = cz; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Expected sequence for one instruction, written from the requirements.
    task automatic run(input logic [5:0] op, input logic z, input logic ov);
        cyc(op, z, ov, 1'b1, V_FETCH, 1'b1, 0, "R2 fetch");
        cyc(op, z, ov, 1'b1, V_DECODE, 1'b0, 0, "R3 decode");
        case (op)
            6'b100011: begin
                cyc(op, z, ov, 1'b1, V_ADDR, 1'b0, 0, "R4 load addr");
                cyc(op, z, ov, 1'b1, V_MRD, 1'b0, 0, "R4 load read");
                cyc(op, z, ov, 1'b1, V_LDWB, 1'b0, 0, "R4 load writeback");
            end
            6'b101011: begin
                cyc(op, z, ov, 1'b1, V_ADDR, 1'b0, 0, "R5 store addr");
                cyc(op, z, ov, 1'b1, V_MWR, 1'b0, 0, "R5 store write");
            end
            6'b000000: begin
                cyc(op, z, ov, 1'b1, V_REXE, 1'b0, 0, "R6 execute");
                if (ov) cyc(op, z, 1'b0, 1'b1, V_EXC, 1'b1, 1, "R11 overflow exception");
                else    cyc(op, z, ov, 1'b1, V_RWB, 1'b0, 0, "R6 writeback");
            end
            6'b000100: cyc(op, z, ov, 1'b1, V_BRANCH, z, 0, "R7 branch / R9 enable");
            6'b000010: cyc(op, z, ov, 1'b1, V_JUMP, 1'b1, 0, "R8 jump");
            default:   cyc(op, z, ov, 1'b1, V_EXC, 1'b1, 0, "R10 undefined / R12 exception");
        endcase
    endtask

    // Monitor: compare ports with the oldest queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [17:0] act;
                e = q.pop_front();
                act = {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_from_mem,
                       ir_wr, dst_sel, reg_wr, alu_a_sel, alu_b_sel, alu_op,
                       pc_src, epc_wr, cause_wr};
                n_chk++;
                if (act !== e.ctl || pc_en !== e.en || cause_val !== e.cause) begin
                    n_bad++;
                    $display("FAIL %s: ctl=%b en=%b cause=%0d expected ctl=%b en=%b cause=%0d (R13 defaults)",
                             e.tag, act, pc_en, cause_val, e.ctl, e.en, e.cause);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_FETCH, 1'b1, 0, "R1 reset to fetch");
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_DECODE, 1'b0, 0, "R3 decode after reset");
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_ADDR, 1'b0, 0, "R4 load addr");
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_MRD, 1'b0, 0, "R4 load read");
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_LDWB, 1'b0, 0, "R4 load writeback");
        run(6'b100011, 1'b1, 1'b1);   // R11: overflow outside execute ignored
        run(6'b101011, 1'b0, 1'b0);   // R5
        run(6'b000000, 1'b0, 1'b0);   // R6
        run(6'b000000, 1'b1, 1'b1);   // R11
        run(6'b000000, 1'b0, 1'b0);   // R6 after exception: cause cleared at port
        run(6'b000100, 1'b1, 1'b0);   // R7 taken
        run(6'b000100, 1'b0, 1'b0);   // R7 not taken
        run(6'b000010, 1'b1, 1'b0);   // R8
        run(6'b111111, 1'b0, 1'b0);   // R10
        run(6'b000001, 1'b0, 1'b1);   // R10 with overflow present
        // R1: reset during the load read step returns to fetch.
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_FETCH, 1'b1, 0, "R2 fetch");
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_DECODE, 1'b0, 0, "R3 decode");
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_ADDR, 1'b0, 0, "R4 load addr");
        cyc(6'b100011, 1'b0, 1'b0, 1'b0, V_MRD, 1'b0, 0, "R1 state held until edge");
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_FETCH, 1'b1, 0, "R1 mid-instruction reset");
        cyc(6'b100011, 1'b0, 1'b0, 1'b1, V_DECODE, 1'b0, 0, "R3 decode after reset");
        repeat (2) @(negedge clk);
        done = 1'b1;
        if (q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R13 scoreboard: %0d items left, expected 0", q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule